// File: doc/BRIEF.md
# LDPC Decoder Syndrome Stall Detector

This block sits beside an iterative LDPC decoder. It watches the vector of parity-check results that the decoder produces at the end of every iteration. When the vector is all zero, the decoder holds a valid codeword and the block raises a valid flag. A vector can instead be nonzero and stay exactly the same over a programmable number of consecutive iterations. That is the mark of a decoder caught in a trapping set, and the block then raises a trap flag. Control logic can use the trap flag to start a recovery action before the iteration limit is reached.

Each check bit is compared with its value from the previous iteration. The differences are reduced by an OR tree into a single "something changed" signal. A second OR tree reduces the raw bits into a "nonzero" signal. A saturating counter records how many back-to-back iterations have left the syndrome unchanged. A start-of-frame pulse clears the history, so the first iteration of a frame is never counted as stable. All outputs are registered and move only on an iteration strobe or a start pulse.

Top module: `ldpc_trap_detector`

## Requirements
- R1: After synchronous reset, trap_flag, valid_flag and stable_cnt are all 0.
- R2: After an iteration strobe, valid_flag is 1 exactly when the strobed syndrome was all zero. An all-zero syndrome never sets trap_flag, and it forces stable_cnt to 0.
- R3: On an iteration strobe whose syndrome differs from the previous strobed syndrome in any bit, stable_cnt becomes 0.
- R4: On a strobe whose nonzero syndrome equals the previous one, stable_cnt increases by 1. The count saturates at STABLE_ITERS (default 3) and never exceeds it.
- R5: After a strobe, trap_flag is 1 exactly when the strobed syndrome is nonzero and stable_cnt has reached STABLE_ITERS.
- R6: The first strobe after reset or after frame_start is treated as a change, so it leaves stable_cnt at 0 whatever the syndrome is.
- R7: In cycles with neither iter_done nor frame_start, all three outputs hold their values.
- R8: frame_start clears stable_cnt, trap_flag and valid_flag on the next edge. It takes priority over a simultaneous iter_done, and that strobe's syndrome is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse at the start of a new frame; clears the history |
| iter_done | input | 1 | One-cycle strobe: chk_bits holds this iteration's syndrome |
| chk_bits | input | CHECKS | Per-check parity results, where 1 means the check is unsatisfied |
| trap_flag | output | 1 | Registered: stalled nonzero syndrome detected |
| valid_flag | output | 1 | Registered: last strobed syndrome was all zero |
| stable_cnt | output | $clog2(STABLE_ITERS+1) | Registered count of consecutive unchanged nonzero iterations |

## Verification
The block is driven with several kinds of syndrome sequence.

- Runs of a repeated nonzero syndrome walk the counter up to saturation. They separate a correct threshold from an off-by-one trap.
- Single-bit flips in a long run show whether every check position reaches the change tree.
- Repeated all-zero syndromes show whether a stable zero is wrongly counted or flagged as a trap.
- Idle gaps between strobes, start pulses mid-run and start pulses coinciding with a strobe cover holding, clearing and priority.
- Seeded random sequences, weighted toward repeats, mix all of these cases. They are checked against a bench model of the counter.

// File: rtl/ldpc_trap_pkg.sv
package ldpc_trap_pkg;
  // Counter width able to hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/ldpc_or_tree.sv
module ldpc_or_tree #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] bits_in,
  output logic             any_set
);
  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 0;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  logic [NODES-1:0] node;

  genvar g;
  generate
    for (g = 0; g < LEAVES; g++) begin : g_leaf
      if (g < WIDTH) begin : g_used
        assign node[LEAVES - 1 + g] = bits_in[g];
      end else begin : g_pad
        assign node[LEAVES - 1 + g] = 1'b0;
      end
    end
    for (g = 0; g < LEAVES - 1; g++) begin : g_inner
      assign node[g] = node[2*g + 1] | node[2*g + 2];
    end
  endgenerate

  assign any_set = node[0];
endmodule

// File: rtl/ldpc_stable_ctr.sv
module ldpc_stable_ctr #(
  parameter int LIMIT = 3,
  parameter int CW    = ldpc_trap_pkg::cnt_width(LIMIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  input  logic          unchanged,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt
);
  localparam logic [CW-1:0] MAXV = CW'(LIMIT);

  always_comb begin
    cnt_nxt = cnt;
    if (clr) begin
      cnt_nxt = '0;
    end else if (step) begin
      if (!unchanged)       cnt_nxt = '0;
      else if (cnt < MAXV)  cnt_nxt = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    cnt <= MAXV);  // R4
  AST_CNT_STEPS_BY_ONE: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && unchanged && cnt < MAXV) |=> cnt == $past(cnt) + 1'b1);  // R4
endmodule

// File: rtl/ldpc_trap_detector.sv
module ldpc_trap_detector #(
  parameter int CHECKS       = 16,
  parameter int STABLE_ITERS = 3,
  parameter int CW           = ldpc_trap_pkg::cnt_width(STABLE_ITERS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              iter_done,
  input  logic [CHECKS-1:0] chk_bits,
  output logic              trap_flag,
  output logic              valid_flag,
  output logic [CW-1:0]     stable_cnt
);
  localparam logic [CW-1:0] MAXV = CW'(STABLE_ITERS);

  logic [CHECKS-1:0] prev_bits;
  logic              primed;
  logic              any_diff;
  logic              nonzero;
  logic              unchanged;
  logic [CW-1:0]     cnt_nxt;

  ldpc_or_tree #(.WIDTH(CHECKS)) u_diff_tree (
    .bits_in (chk_bits ^ prev_bits),
    .any_set (any_diff)
  );

  ldpc_or_tree #(.WIDTH(CHECKS)) u_zero_tree (
    .bits_in (chk_bits),
    .any_set (nonzero)
  );

  // Unchanged only once a previous syndrome exists, and only for a nonzero one
  assign unchanged = primed && !any_diff && nonzero;

  ldpc_stable_ctr #(.LIMIT(STABLE_ITERS), .CW(CW)) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .clr       (frame_start),
    .step      (iter_done),
    .unchanged (unchanged),
    .cnt       (stable_cnt),
    .cnt_nxt   (cnt_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      prev_bits  <= '0;
      primed     <= 1'b0;
      trap_flag  <= 1'b0;
      valid_flag <= 1'b0;
    end else if (iter_done) begin
      prev_bits  <= chk_bits;
      primed     <= 1'b1;
      valid_flag <= !nonzero;
      trap_flag  <= nonzero && (cnt_nxt == MAXV);
    end
  end

  AST_TRAP_NOT_VALID: assert property (@(posedge clk) disable iff (rst)
    trap_flag |-> !valid_flag);  // R2
  AST_TRAP_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    trap_flag |-> stable_cnt == MAXV);  // R5
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!iter_done && !frame_start) |=> $stable(stable_cnt) && $stable(trap_flag) && $stable(valid_flag));  // R7
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> stable_cnt == '0 && !trap_flag && !valid_flag);  // R8
  AST_CHANGE_RESETS: assert property (@(posedge clk) disable iff (rst)
    (iter_done && !frame_start && any_diff) |=> stable_cnt == '0);  // R3
endmodule

// File: tb/ldpc_trap_detector_tb.sv
module ldpc_trap_detector_tb_top;
  localparam int M  = 16;
  localparam int D  = 3;
  localparam int CW = $clog2(D + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          frame_start = 1'b0;
  logic          iter_done = 1'b0;
  logic [M-1:0]  chk_bits = '0;
  logic          trap_flag, valid_flag;
  logic [CW-1:0] stable_cnt;

  int checks = 0;
  int errors = 0;

  // bench model state
  logic [M-1:0] m_prev = '0;
  bit           m_primed = 0;
  int           m_cnt = 0;
  bit           m_trap = 0;
  bit           m_valid = 0;

  always #5 clk = ~clk;

  ldpc_trap_detector #(.CHECKS(M), .STABLE_ITERS(D)) dut_i (
    .clk(clk), .rst(rst), .frame_start(frame_start), .iter_done(iter_done),
    .chk_bits(chk_bits), .trap_flag(trap_flag), .valid_flag(valid_flag),
    .stable_cnt(stable_cnt)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string rc, input string rt, input string rv);
    check(rc, int'(stable_cnt), m_cnt);
    check(rt, int'(trap_flag), int'(m_trap));
    check(rv, int'(valid_flag), int'(m_valid));
  endtask

  function automatic void model_clear();
    m_cnt = 0; m_trap = 0; m_valid = 0; m_primed = 0; m_prev = '0;
  endfunction

  function automatic void model_step(input logic [M-1:0] s);
    bit chg, zero;
    chg  = !m_primed || (s != m_prev);
    zero = (s == '0);
    if (zero || chg) m_cnt = 0;
    else if (m_cnt < D) m_cnt++;
    m_trap   = !zero && (m_cnt == D);
    m_valid  = zero;
    m_prev   = s;
    m_primed = 1;
  endfunction

  // inputs are driven at the falling edge; outputs are checked at the falling edge after the strobe
  task automatic strobe(input logic [M-1:0] s, input string rc);
    chk_bits = s; iter_done = 1'b1;
    @(negedge clk);
    iter_done = 1'b0;
    model_step(s);
    check_all(rc, "R5", "R2");
  endtask

  task automatic start_pulse(input bit with_strobe, input logic [M-1:0] s);
    frame_start = 1'b1; iter_done = with_strobe; chk_bits = s;
    @(negedge clk);
    frame_start = 1'b0; iter_done = 1'b0;
    model_clear();
    check_all("R8", "R8", "R8");
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [M-1:0] cur;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check_all("R1", "R1", "R1");

    // R6: the first strobe counts as a change
    strobe(16'h0081, "R6");
    // R4: repeats climb and saturate; R5: trap appears at the limit
    for (int i = 0; i < 5; i++) strobe(16'h0081, "R4");
    // R7: idle cycles hold every output
    repeat (4) @(negedge clk);
    check_all("R7", "R7", "R7");
    // R3: a single bit flip clears the count, for every position
    for (int b = 0; b < M; b++) begin
      strobe(16'h0081 ^ (16'h1 << b), "R3");
      strobe(16'h0081, "R3");
    end
    // R2: a stable zero syndrome is valid, never a trap, and keeps count 0
    for (int i = 0; i < 5; i++) strobe(16'h0000, "R2");
    // R8: start mid-run, then start with a coincident strobe
    for (int i = 0; i < 4; i++) strobe(16'h4000, "R4");
    start_pulse(0, '0);
    strobe(16'h4000, "R6");
    strobe(16'h4000, "R4");
    start_pulse(1, 16'h4000);
    strobe(16'h4000, "R6");

    // seeded random, weighted toward repeats
    cur = 16'h0003;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 5) begin
        start_pulse(0, '0);
      end else begin
        if (r < 10)      cur = '0;
        else if (r < 20) cur = M'($urandom);
        else if (r < 28) cur = cur ^ (M'(1) << $urandom_range(0, M-1));
        strobe(cur, "R4");
        if (r > 95) begin
          repeat ($urandom_range(1, 3)) @(negedge clk);
          check_all("R7", "R7", "R7");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule